// File: doc/BRIEF.md
# Real-Time Clock Peripheral

This block is a memory-mapped real-time clock. It holds one 32-bit packed time-of-day word made of seconds, minutes, hours and a running day count. The word advances once per second. A prescaler divides the system clock down to a one-second tick, and software turns that prescaler on or off through an enable register.

The block also has an alarm comparator, a stopwatch down-counter that stops at zero, an interrupt status register with write-one-to-clear bits, an interrupt enable mask and a single level-sensitive interrupt line. Software reaches all of it over a single-cycle register bus. The bus accepts 16-bit and 32-bit accesses only, and it reports an access error for any other size or for an unmapped offset.

Top module: `rtc_top`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low.
- R2: The time word packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and a day count in bits 31:17. Register offsets are: time 0x00, interrupt enable 0x04, interrupt status 0x08, stopwatch 0x0C, alarm 0x10, prescaler enable 0x14. A 32-bit write to time or alarm reads back unchanged.
- R3: While bit 0 of the prescaler-enable register is set, a tick occurs once every `CLK_PER_TICK` clock cycles. Each tick advances the time by one second. While the bit is clear, the time word does not change.
- R4: Seconds at 59 or above wrap to 0 and carry into minutes. Minutes at 59 or above wrap to 0 and carry into hours. Hours at 23 or above wrap to 0 and increment the day count.
- R5: Every tick sets status bit 2. A seconds carry also sets bit 3, a minutes carry also sets bit 4, and a day increment also sets bit 5.
- R6: When the time word after a tick equals the alarm register, status bit 0 is set.
- R7: The stopwatch decrements by one on each tick while it is non-zero. A tick that takes it from 1 to 0 sets status bit 1. At 0 it stays at 0 and sets nothing more.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Bit 14 is set by any write to the time register and cannot be cleared by software. A set event in the same cycle as a clear wins.
- R9: `irq` is high exactly while (status AND enable) is non-zero.
- R10: The value of `bus_size` is the access size in bytes. Only 2 and 4 are legal. Any other size returns `bus_err` = 01 and read data 0, and a write of that size changes nothing.
- R11: An access whose offset is not a multiple of 4, or whose offset lies beyond 0x14, returns `bus_err` = 10. A size error takes precedence over an unmapped offset. A legal access returns 00.
- R12: A 16-bit write to a 32-bit register replaces bits 15:0 and keeps bits 31:16. A 16-bit read returns bits 15:0 with the upper half zero. A 32-bit write to a 16-bit register keeps only bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 2 | Access status: 00 ok, 01 size, 10 unmapped |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones that need an exact number of one-second ticks. Examples are a stopwatch that reaches zero, an alarm match and a full carry from seconds through to the day count. Ticks arrive only from the prescaler, so the bench sets the enable bit and waits exactly `CLK_PER_TICK`-1 idle cycles. It then clears the bit in the cycle in which the single tick fires. This gives exactly one tick per call. The time and stopwatch are preloaded over the bus to values one step short of the event under test.

// File: rtl/rtc_pkg.sv
// Shared types and constants for the real-time clock block.
// Assumes a 32-bit data bus and a fixed six-register map at 4-byte stride.
package rtc_pkg;

    // Packed time word; field positions are architectural
    typedef struct packed {
        logic [14:0] day;
        logic [4:0]  hour;
        logic [5:0]  min;
        logic [5:0]  sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ACC_OK       = 2'b00,
        ACC_SIZE     = 2'b01,
        ACC_UNMAPPED = 2'b10
    } acc_status_e;

    // Register indices (offset / 4)
    localparam int REG_TIME  = 0;
    localparam int REG_IEN   = 1;
    localparam int REG_STAT  = 2;
    localparam int REG_SWCNT = 3;
    localparam int REG_ALARM = 4;
    localparam int REG_PREN  = 5;
    localparam int NUM_REGS  = 6;

    // Status bit positions
    localparam int ST_ALARM  = 0;
    localparam int ST_SWDONE = 1;
    localparam int ST_SEC    = 2;
    localparam int ST_MIN    = 3;
    localparam int ST_HOUR   = 4;
    localparam int ST_DAY    = 5;
    localparam int ST_LOADED = 14;

    localparam int REG16_W = 16;

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the system clock down to a one-cycle tick every DIV cycles.
// Assumes DIV >= 2. The count restarts from zero whenever en is low.
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Count cycles while enabled; wrap at the last one, clear when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_idle_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0 && !tick));

endmodule

// File: rtl/rtc_timekeeper.sv
// Holds the packed time word and advances it by one second per tick.
// A load in the same cycle as a tick wins. Fields above their normal
// maximum are treated as at maximum for carry purposes.
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      ld,
    input  rtc_time_t ld_data,
    input  rtc_time_t alarm,
    output rtc_time_t time_q,
    output logic      evt_sec,
    output logic      evt_min,
    output logic      evt_hour,
    output logic      evt_day,
    output logic      evt_alarm
);
    rtc_time_t nxt;
    logic      sec_wrap;
    logic      min_wrap;
    logic      hour_wrap;
    logic      step;

    assign step = tick && !ld;

    // Compute the one-second successor and the carry chain
    always_comb begin
        sec_wrap  = (time_q.sec >= 6'd59);
        min_wrap  = sec_wrap && (time_q.min >= 6'd59);
        hour_wrap = min_wrap && (time_q.hour >= 5'd23);
        nxt       = time_q;
        nxt.sec   = sec_wrap ? 6'd0 : time_q.sec + 6'd1;
        if (sec_wrap) begin
            nxt.min = (time_q.min >= 6'd59) ? 6'd0 : time_q.min + 6'd1;
        end
        if (min_wrap) begin
            nxt.hour = (time_q.hour >= 5'd23) ? 5'd0 : time_q.hour + 5'd1;
        end
        if (hour_wrap) begin
            nxt.day = time_q.day + 15'd1;
        end
    end

    // Status events raised by a tick that actually advances the word
    assign evt_sec   = step;
    assign evt_min   = step && sec_wrap;
    assign evt_hour  = step && min_wrap;
    assign evt_day   = step && hour_wrap;
    assign evt_alarm = step && (nxt == alarm);

    // Time register: load from bus, else advance on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (ld) begin
            time_q <= ld_data;
        end else if (tick) begin
            time_q <= nxt;
        end
    end

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(time_q));
    p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && time_q.sec >= 6'd59) |=> (time_q.sec == 6'd0));
    p_sec_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && time_q.sec < 6'd59) |=> (time_q.sec == $past(time_q.sec) + 6'd1));
    p_day_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && time_q.hour < 5'd23) |=> (time_q.day == $past(time_q.day)));

endmodule

// File: rtl/rtc_stopwatch.sv
// Down-counter decremented once per tick; flags the 1-to-0 step and
// then rests at zero. A load in the same cycle as a tick wins.
module rtc_stopwatch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] cnt_q,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    assign expire = tick && !ld && (cnt_q == ONE);

    // Counter: load from bus, else decrement on tick while non-zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_data;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    p_zero_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !ld) |=> (cnt_q == '0));
    p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/rtc_top.sv
// Real-time clock peripheral: register decode, status/enable registers,
// interrupt output, and the prescaler, timekeeper and stopwatch.
// Assumes one access per cycle; reads are combinational in the access cycle,
// writes commit at the clock edge that ends it.
module rtc_top
    import rtc_pkg::*;
#(
    parameter int CLK_PER_TICK = 32768,
    parameter int ADDR_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        bus_err,
    output logic              irq
);
    localparam int IDXW = ADDR_W - 2;
    localparam logic [REG16_W-1:0] KEEP_MASK = REG16_W'(1) << ST_LOADED;

    logic [IDXW-1:0]    idx;
    logic               size_ok;
    logic               map_ok;
    acc_status_e        acc;
    logic               wr_ok;
    logic [31:0]        lane_mask;
    logic               wr_time, wr_ien, wr_stat, wr_sw, wr_alarm, wr_pren;

    rtc_time_t          time_q;
    rtc_time_t          time_ld;
    rtc_time_t          alarm_q;
    logic [REG16_W-1:0] ien_q;
    logic [REG16_W-1:0] stat_q;
    logic [REG16_W-1:0] pren_q;
    logic [REG16_W-1:0] sw_q;
    logic [REG16_W-1:0] stat_set;
    logic [REG16_W-1:0] stat_clr;
    logic [31:0]        rd_raw;

    logic tick;
    logic evt_sec, evt_min, evt_hour, evt_day, evt_alarm, sw_expire;

    // Access decode: size check first, then offset check
    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        size_ok = (bus_size == 3'd2) || (bus_size == 3'd4);
        map_ok  = (bus_addr[1:0] == 2'b00) && (int'(idx) < NUM_REGS);
        if (!bus_sel)      acc = ACC_OK;
        else if (!size_ok) acc = ACC_SIZE;
        else if (!map_ok)  acc = ACC_UNMAPPED;
        else               acc = ACC_OK;
    end

    assign bus_err   = acc;
    assign wr_ok     = bus_sel && bus_wr && (acc == ACC_OK);
    assign lane_mask = (bus_size == 3'd4) ? 32'hFFFF_FFFF : 32'h0000_FFFF;

    assign wr_time  = wr_ok && (idx == IDXW'(REG_TIME));
    assign wr_ien   = wr_ok && (idx == IDXW'(REG_IEN));
    assign wr_stat  = wr_ok && (idx == IDXW'(REG_STAT));
    assign wr_sw    = wr_ok && (idx == IDXW'(REG_SWCNT));
    assign wr_alarm = wr_ok && (idx == IDXW'(REG_ALARM));
    assign wr_pren  = wr_ok && (idx == IDXW'(REG_PREN));

    // Merge write data into the time word by access width
    assign time_ld = (time_q & ~lane_mask) | (bus_wdata & lane_mask);

    rtc_prescaler #(.DIV(CLK_PER_TICK)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pren_q[0]),
        .tick  (tick)
    );

    rtc_timekeeper u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ld        (wr_time),
        .ld_data   (time_ld),
        .alarm     (alarm_q),
        .time_q    (time_q),
        .evt_sec   (evt_sec),
        .evt_min   (evt_min),
        .evt_hour  (evt_hour),
        .evt_day   (evt_day),
        .evt_alarm (evt_alarm)
    );

    rtc_stopwatch #(.W(REG16_W)) u_sw (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld      (wr_sw),
        .ld_data (bus_wdata[REG16_W-1:0]),
        .cnt_q   (sw_q),
        .expire  (sw_expire)
    );

    // Plain read/write registers: enable mask, alarm, prescaler enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q   <= '0;
            alarm_q <= '0;
            pren_q  <= '0;
        end else begin
            if (wr_ien)   ien_q   <= bus_wdata[REG16_W-1:0];
            if (wr_alarm) alarm_q <= (alarm_q & ~lane_mask) | (bus_wdata & lane_mask);
            if (wr_pren)  pren_q  <= bus_wdata[REG16_W-1:0];
        end
    end

    // Gather status set events and the software clear mask
    always_comb begin
        stat_set            = '0;
        stat_set[ST_ALARM]  = evt_alarm;
        stat_set[ST_SWDONE] = sw_expire;
        stat_set[ST_SEC]    = evt_sec;
        stat_set[ST_MIN]    = evt_min;
        stat_set[ST_HOUR]   = evt_hour;
        stat_set[ST_DAY]    = evt_day;
        stat_set[ST_LOADED] = wr_time;
        stat_clr = wr_stat ? (bus_wdata[REG16_W-1:0] & ~KEEP_MASK) : '0;
    end

    // Status register: clear-by-one, then set (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    // Interrupt line
    assign irq = |(stat_q & ien_q);

    // Read mux, truncated for 16-bit reads, zero on any error
    always_comb begin
        case (int'(idx))
            REG_TIME:  rd_raw = time_q;
            REG_IEN:   rd_raw = {16'h0, ien_q};
            REG_STAT:  rd_raw = {16'h0, stat_q};
            REG_SWCNT: rd_raw = {16'h0, sw_q};
            REG_ALARM: rd_raw = alarm_q;
            REG_PREN:  rd_raw = {16'h0, pren_q};
            default:   rd_raw = '0;
        endcase
        if (!bus_sel || bus_wr || acc != ACC_OK) begin
            bus_rdata = '0;
        end else begin
            bus_rdata = rd_raw & lane_mask;
        end
    end

    p_loaded_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[ST_LOADED] |=> stat_q[ST_LOADED]);
    p_err_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_err != 2'b00)
            |=> ($stable(ien_q) && $stable(alarm_q) && $stable(pren_q)));
    p_size_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_size != 3'd2 && bus_size != 3'd4) |-> (bus_err == 2'b01));
    p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/tb_rtc_top.sv
`timescale 1ns/1ps
module tb_rtc_top;
    localparam int DIV = 4;
    localparam int AW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [1:0]    bus_err;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] rd;
        logic [1:0]  err;
        bit          chk_rd;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    rtc_top #(.CLK_PER_TICK(DIV), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq)
    );

    function automatic logic [31:0] pk(int d, int h, int m, int s);
        return {15'(d), 5'(h), 6'(m), 6'(s)};
    endfunction

    // Driver: one access per cycle, expected result queued for the monitor
    task automatic bus(bit wr, logic [AW-1:0] a, logic [2:0] sz, logic [31:0] wd,
                       logic [31:0] erd, logic [1:0] eerr, bit chk, string tag);
        exp_t e;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        e.rd = erd; e.err = eerr; e.chk_rd = chk; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic wr32(logic [AW-1:0] a, logic [31:0] d, string tag);
        bus(1'b1, a, 3'd4, d, '0, 2'b00, 1'b0, tag);
    endtask
    task automatic wr16(logic [AW-1:0] a, logic [31:0] d, string tag);
        bus(1'b1, a, 3'd2, d, '0, 2'b00, 1'b0, tag);
    endtask
    task automatic rd32(logic [AW-1:0] a, logic [31:0] e, string tag);
        bus(1'b0, a, 3'd4, '0, e, 2'b00, 1'b1, tag);
    endtask
    task automatic rd16(logic [AW-1:0] a, logic [31:0] e, string tag);
        bus(1'b0, a, 3'd2, '0, e, 2'b00, 1'b1, tag);
    endtask

    // Exactly one prescaler tick: enable, wait DIV-1 cycles, disable on the tick
    task automatic one_tick();
        wr16(5'h14, 32'h1, "R3");
        idle(DIV - 1);
        wr16(5'h14, 32'h0, "R3");
    endtask

    task automatic chk_irq(logic e, string tag);
        idle(1);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // Monitor: compare each access mid-cycle against the queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_sel) begin
            if (expq.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (bus_err !== e.err) begin
                    failures++;
                    $display("FAIL %s err actual=%b expected=%b", e.tag, bus_err, e.err);
                end
                if (e.chk_rd) begin
                    checks++;
                    if (bus_rdata !== e.rd) begin
                        failures++;
                        $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.rd);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd32(5'h00, 32'h0, "R1 time");
        rd32(5'h04, 32'h0, "R1 ien");
        rd32(5'h08, 32'h0, "R1 stat");
        rd32(5'h0C, 32'h0, "R1 sw");
        rd32(5'h10, 32'h0, "R1 alarm");
        rd32(5'h14, 32'h0, "R1 pren");
        chk_irq(1'b0, "R1");

        // R2: layout and readback; R8: time write sets bit 14
        wr32(5'h00, pk(5, 10, 20, 30), "R2");
        rd32(5'h00, pk(5, 10, 20, 30), "R2 time readback");
        rd32(5'h08, 32'h4000, "R8 loaded bit");

        // R3/R5: one tick advances one second and sets bit 2
        one_tick();
        rd32(5'h00, pk(5, 10, 20, 31), "R3 tick");
        rd32(5'h08, 32'h4004, "R5 sec event");
        idle(20);
        rd32(5'h00, pk(5, 10, 20, 31), "R3 no tick when disabled");

        // R4/R5: full carry to day
        wr32(5'h00, pk(7, 23, 59, 59), "R4");
        wr32(5'h08, 32'hFFFF, "R8");
        one_tick();
        rd32(5'h00, pk(8, 0, 0, 0), "R4 full carry");
        rd32(5'h08, 32'h403C, "R5 carry events");
        wr32(5'h08, 32'hFFFF, "R8");
        rd32(5'h08, 32'h4000, "R8 w1c keeps bit14");

        // R4/R5: seconds-only carry
        wr32(5'h00, pk(2, 3, 58, 59), "R4");
        wr32(5'h08, 32'hFFFF, "R8");
        one_tick();
        rd32(5'h00, pk(2, 3, 59, 0), "R4 sec carry");
        rd32(5'h08, 32'h400C, "R5 minute event");

        // R6/R9: alarm match and interrupt
        wr32(5'h10, pk(1, 2, 3, 5), "R2");
        rd32(5'h10, pk(1, 2, 3, 5), "R2 alarm readback");
        wr32(5'h00, pk(1, 2, 3, 4), "R6");
        wr32(5'h08, 32'hFFFF, "R8");
        wr32(5'h04, 32'h0001, "R9");
        chk_irq(1'b0, "R9 masked quiet");
        one_tick();
        rd32(5'h08, 32'h4005, "R6 alarm bit");
        chk_irq(1'b1, "R9 alarm irq");
        wr32(5'h08, 32'h0001, "R8");
        rd32(5'h08, 32'h4004, "R8 single bit clear");
        chk_irq(1'b0, "R9 after clear");

        // R7: stopwatch
        wr32(5'h08, 32'hFFFF, "R8");
        wr32(5'h04, 32'h0002, "R9");
        wr32(5'h0C, 32'h2, "R7");
        rd32(5'h0C, 32'h2, "R7 load");
        one_tick();
        rd32(5'h0C, 32'h1, "R7 dec");
        rd32(5'h08, 32'h4004, "R7 no early expire");
        one_tick();
        rd32(5'h0C, 32'h0, "R7 zero");
        rd32(5'h08, 32'h4006, "R7 expire bit");
        chk_irq(1'b1, "R9 sw irq");
        wr32(5'h08, 32'hFFFF, "R8");
        one_tick();
        rd32(5'h0C, 32'h0, "R7 rest at zero");
        rd32(5'h08, 32'h4004, "R7 no re-expire");

        // R8/R9: bit 14 drives irq and survives clear
        wr32(5'h04, 32'h4000, "R9");
        chk_irq(1'b1, "R9 bit14 irq");
        wr32(5'h08, 32'hFFFF, "R8");
        rd32(5'h08, 32'h4000, "R8 bit14 stuck");
        chk_irq(1'b1, "R8 irq stays");
        wr32(5'h04, 32'h0, "R9");
        chk_irq(1'b0, "R9 mask off");

        // R10: size errors
        bus(1'b1, 5'h04, 3'd1, 32'hFF, '0, 2'b01, 1'b0, "R10 byte write");
        rd32(5'h04, 32'h0, "R10 no effect");
        bus(1'b0, 5'h00, 3'd1, '0, 32'h0, 2'b01, 1'b1, "R10 byte read");
        bus(1'b0, 5'h00, 3'd3, '0, 32'h0, 2'b01, 1'b1, "R10 size3");

        // R11: unmapped and priority
        bus(1'b0, 5'h1C, 3'd1, '0, 32'h0, 2'b01, 1'b1, "R11 size beats map");
        bus(1'b0, 5'h1C, 3'd4, '0, 32'h0, 2'b10, 1'b1, "R11 unmapped");
        bus(1'b0, 5'h02, 3'd2, '0, 32'h0, 2'b10, 1'b1, "R11 misaligned");
        bus(1'b1, 5'h18, 3'd4, 32'h1, '0, 2'b10, 1'b0, "R11 unmapped write");

        // R12: mixed widths
        wr32(5'h10, 32'hAAAA5555, "R12");
        wr16(5'h10, 32'hFFFF1234, "R12");
        rd32(5'h10, 32'hAAAA1234, "R12 half write");
        rd16(5'h10, 32'h00001234, "R12 half read");
        wr32(5'h04, 32'hFFFF0003, "R12");
        rd32(5'h04, 32'h00000003, "R12 16bit reg");
        chk_irq(1'b0, "R9 no match");

        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule